// File: doc/BRIEF.md
# Fused Multiply-Add Special-Value and Sign Stage

This block sits at the output of a binary64 fused multiply-add datapath. It takes the three operands A, C and B and a 5-bit variant code. The variant code selects one of four operations: A×C+B, A×C−B, −(A×C+B) and −(A×C−B). The datapath computes the finite, already-rounded value of A×C plus B or minus B and presents it on `fin_res` with the strobe `fin_valid`. `fin_res` carries its sign, and the negated variants are not applied to it. This block decides whether that value or a special value is the answer. The special cases are NaN propagation, the invalid products and sums, and infinite results. It also applies the final sign inversion of the negated variants, which is a pure flip of bit 63 and never touches a NaN.

Alongside the result, the block keeps a set of sticky exception bits that only the `flag_clr` input clears, a summary bit for new exceptions and an enabled-exception summary. When the record bit is set, it also forms a 4-bit record image from these bits. Every registered output appears exactly one clock after the operation is presented.

Top module: `fma_special`

## Requirements
- R1: An operation presented with `op_valid` and a legal code gives `res_valid` high one clock later. With finite, non-NaN operands and no infinity, `res_valid` also needs `fin_valid` high; `res` is then `fin_res` for codes 28 (A×C−B) and 29 (A×C+B), and `fin_res` with only bit 63 inverted for codes 30 (−(A×C−B)) and 31 (−(A×C+B)). Without `fin_valid`, no result appears.
- R2: If any operand is a NaN (exponent all ones, fraction non-zero), `res` is the first NaN in the order A, B, C, with fraction bit 51 forced to 1 and the sign bit unchanged, in every variant.
- R3: A signalling NaN operand (fraction bit 51 clear) sets the sticky `inv_snan` bit.
- R4: A product of zero and infinity, in either order, sets the sticky `inv_zmi` bit. If no operand is a NaN, the result is `DEF_NAN` (default 0x7FF8000000000000).
- R5: If the product is infinite and B is infinite, with the product sign different from the effective sign of B, the sticky `inv_inf_sub` bit is set and the result is `DEF_NAN`. The effective sign of B is its sign bit inverted for codes 28 and 30.
- R6: Otherwise, an infinite product gives an infinity with the product sign, and an infinite B alone gives an infinity with B's effective sign. Bit 63 is inverted afterwards for codes 30 and 31.
- R7: `fin_ox` sets the sticky `ovf` bit only when the finite path supplies the result. All sticky bits hold until `flag_clr`, and `inv_any` is the OR of the three invalid bits.
- R8: `exc_sum` becomes 1 when an operation takes any of `inv_zmi`, `inv_inf_sub`, `inv_snan` or `ovf` from 0 to 1, and stays set until `flag_clr`. `en_sum` = (`inv_any` & `exc_en[1]`) | (`ovf` & `exc_en[0]`).
- R9: When `op_rec` is 1 on a completed operation, `rec_valid` pulses and `rec_img` is loaded with {exc_sum, en_sum, inv_any, ovf}, bit 3 first. Otherwise `rec_img` holds its value.
- R10: A code outside 28..31 pulses `illegal` one clock later. It produces no `res_valid` and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_xo | input | 5 | Variant code |
| op_rec | input | 1 | Record bit |
| exc_en | input | 2 | Exception enables {invalid, overflow} |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B |
| c | input | 64 | Operand C |
| fin_valid | input | 1 | Finite datapath result valid |
| fin_res | input | 64 | Rounded finite result of A×C±B |
| fin_ox | input | 1 | Finite result overflowed |
| flag_clr | input | 1 | Clear all sticky bits |
| res_valid | output | 1 | Result valid |
| res | output | 64 | Final result |
| illegal | output | 1 | Illegal variant code seen |
| inv_zmi | output | 1 | Sticky zero-times-infinity invalid |
| inv_inf_sub | output | 1 | Sticky infinity-minus-infinity invalid |
| inv_snan | output | 1 | Sticky signalling-NaN invalid |
| ovf | output | 1 | Sticky overflow |
| exc_sum | output | 1 | Sticky new-exception summary |
| en_sum | output | 1 | Enabled-exception summary |
| inv_any | output | 1 | Any invalid bit set |
| rec_valid | output | 1 | Record image updated |
| rec_img | output | 4 | Record image |

## Verification
The bench builds the block with the default `DEF_NAN` of 0x7FF8000000000000, so the result of every invalid case can be compared bit for bit with the canonical quiet NaN. A behavioural model in the bench tracks the result and the sticky state on every clock. The stimulus covers zero and infinity in both operand orders, signalling and quiet NaNs in each operand slot, and negative NaNs under the negated codes. Because B's effective sign depends on the code, the infinity-minus-infinity case is applied under both the add and the subtract codes.

// File: rtl/fma_special.sv
module fma_special #(
  parameter logic [63:0] DEF_NAN = 64'h7FF8_0000_0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [4:0]  op_xo,
  input  logic        op_rec,
  input  logic [1:0]  exc_en,
  input  logic [63:0] a,
  input  logic [63:0] b,
  input  logic [63:0] c,
  input  logic        fin_valid,
  input  logic [63:0] fin_res,
  input  logic        fin_ox,
  input  logic        flag_clr,
  output logic        res_valid,
  output logic [63:0] res,
  output logic        illegal,
  output logic        inv_zmi,
  output logic        inv_inf_sub,
  output logic        inv_snan,
  output logic        ovf,
  output logic        exc_sum,
  output logic        en_sum,
  output logic        inv_any,
  output logic        rec_valid,
  output logic [3:0]  rec_img
);

  function automatic logic is_nan(input logic [63:0] x);
    return (&x[62:52]) && (|x[51:0]);
  endfunction
  function automatic logic is_inf(input logic [63:0] x);
    return (&x[62:52]) && !(|x[51:0]);
  endfunction
  function automatic logic is_zero(input logic [63:0] x);
    return !(|x[62:0]);
  endfunction

  wire legal  = (op_xo[4:2] == 3'b111);
  wire do_sub = ~op_xo[0];
  wire do_neg = op_xo[1];

  wire a_nan = is_nan(a), b_nan = is_nan(b), c_nan = is_nan(c);
  wire a_inf = is_inf(a), b_inf = is_inf(b), c_inf = is_inf(c);
  wire any_nan = a_nan | b_nan | c_nan;
  wire any_snan = (a_nan & ~a[51]) | (b_nan & ~b[51]) | (c_nan & ~c[51]);
  wire zmi = (is_zero(a) & c_inf) | (a_inf & is_zero(c));
  wire p_inf = (a_inf | c_inf) & ~zmi & ~a_nan & ~c_nan;
  wire p_sgn = a[63] ^ c[63];
  wire b_sgn = b[63] ^ do_sub;
  wire isi = p_inf & b_inf & (p_sgn != b_sgn);
  wire special = any_nan | zmi | a_inf | c_inf | b_inf;

  logic [63:0] res_n;
  always_comb begin
    if (a_nan)        res_n = a | 64'h0008_0000_0000_0000;
    else if (b_nan)   res_n = b | 64'h0008_0000_0000_0000;
    else if (c_nan)   res_n = c | 64'h0008_0000_0000_0000;
    else if (zmi | isi) res_n = DEF_NAN;
    else if (p_inf)   res_n = {p_sgn ^ do_neg, 11'h7FF, 52'd0};
    else if (b_inf)   res_n = {b_sgn ^ do_neg, 11'h7FF, 52'd0};
    else              res_n = {fin_res[63] ^ do_neg, fin_res[62:0]};
  end

  wire fire = op_valid & legal & (special | fin_valid);

  wire [3:0] cur  = {inv_zmi, inv_inf_sub, inv_snan, ovf};
  wire [3:0] base = flag_clr ? 4'b0 : cur;
  wire [3:0] raised = fire ? {zmi, isi, any_snan, fin_ox & ~special} : 4'b0;
  wire [3:0] nxt  = base | raised;
  wire fx_n  = (exc_sum & ~flag_clr) | (|(raised & ~base));
  wire vx_n  = |nxt[3:1];
  wire fex_n = (vx_n & exc_en[1]) | (nxt[0] & exc_en[0]);

  assign inv_any = inv_zmi | inv_inf_sub | inv_snan;
  assign en_sum  = (inv_any & exc_en[1]) | (ovf & exc_en[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= 64'd0;
      illegal   <= 1'b0;
      {inv_zmi, inv_inf_sub, inv_snan, ovf} <= 4'b0;
      exc_sum   <= 1'b0;
      rec_valid <= 1'b0;
      rec_img   <= 4'b0;
    end else begin
      res_valid <= fire;
      illegal   <= op_valid & ~legal;
      rec_valid <= fire & op_rec;
      if (fire) res <= res_n;
      {inv_zmi, inv_inf_sub, inv_snan, ovf} <= nxt;
      exc_sum   <= fx_n;
      if (fire & op_rec) rec_img <= {fx_n, fex_n, vx_n, nxt[0]};
    end
  end

endmodule

// File: rtl/fma_special_chk.sv
module fma_special_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flag_clr,
  input logic        res_valid,
  input logic [63:0] res,
  input logic        illegal,
  input logic        inv_zmi,
  input logic        inv_inf_sub,
  input logic        inv_snan,
  input logic        ovf,
  input logic        exc_sum,
  input logic        inv_any,
  input logic        rec_valid,
  input logic [3:0]  rec_img
);
  wire res_is_nan = (&res[62:52]) && (|res[51:0]);

  AST_NAN_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_is_nan) |-> res[51]); // R2

  AST_ILLEGAL_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !res_valid); // R10

  AST_ILLEGAL_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !$past(flag_clr)) |->
      $stable({inv_zmi, inv_inf_sub, inv_snan, ovf, exc_sum})); // R10

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && (inv_zmi || inv_inf_sub || inv_snan || ovf)) |=>
      (inv_zmi || inv_inf_sub || inv_snan || ovf)); // R7

  AST_SUMMARY_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(inv_snan) || $rose(inv_zmi) || $rose(inv_inf_sub) || $rose(ovf)) |-> exc_sum); // R8

  AST_REC_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_img[3] == exc_sum && rec_img[1] == inv_any && rec_img[0] == ovf)); // R9
endmodule

bind fma_special fma_special_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .res_valid(res_valid), .res(res),
  .illegal(illegal), .inv_zmi(inv_zmi), .inv_inf_sub(inv_inf_sub), .inv_snan(inv_snan),
  .ovf(ovf), .exc_sum(exc_sum), .inv_any(inv_any), .rec_valid(rec_valid), .rec_img(rec_img)
);

// File: tb/tb_fma_special.sv
module tb_fma_special;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_rec = 0, fin_valid = 0, fin_ox = 0, flag_clr = 0;
  logic [4:0] op_xo = 0;
  logic [1:0] exc_en = 0;
  logic [63:0] a = 0, b = 0, c = 0, fin_res = 0;
  logic res_valid, illegal, inv_zmi, inv_inf_sub, inv_snan, ovf, exc_sum, en_sum, inv_any, rec_valid;
  logic [63:0] res;
  logic [3:0] rec_img;

  fma_special dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;

  localparam logic [63:0] P_INF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] ZERO  = 64'h0;
  localparam logic [63:0] QNAN1 = 64'h7FF8_0000_0000_0011;
  localparam logic [63:0] NQNAN = 64'hFFF8_0000_0000_0022;
  localparam logic [63:0] SNAN1 = 64'h7FF0_0000_0000_0033;
  localparam logic [63:0] DNAN  = 64'h7FF8_0000_0000_0000;

  bit m_zmi, m_isi, m_snan, m_ovf, m_fx;
  bit [3:0] m_rec;
  bit [63:0] m_res;
  bit e_fire, e_ill;

  function automatic bit f_nan(bit [63:0] x); return x[62:52] == 11'h7FF && x[51:0] != 0; endfunction
  function automatic bit f_inf(bit [63:0] x); return x[62:52] == 11'h7FF && x[51:0] == 0; endfunction
  function automatic bit f_zero(bit [63:0] x); return x[62:0] == 0; endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit [4:0] xo, bit rec, bit [63:0] ia, bit [63:0] ib,
                      bit [63:0] ic, bit fv, bit [63:0] fr, bit fo, bit clr);
    bit neg, sub, nanin, zmi, isi, pinf, binf, snan, ovfr, fxn;
    bit ps, bs;
    bit [63:0] r;
    op_valid = v; op_xo = xo; op_rec = rec; a = ia; b = ib; c = ic;
    fin_valid = fv; fin_res = fr; fin_ox = fo; flag_clr = clr;
    if (clr) begin m_zmi = 0; m_isi = 0; m_snan = 0; m_ovf = 0; m_fx = 0; end
    e_ill = v && (xo < 28);
    sub = (xo == 28 || xo == 30);
    neg = (xo == 30 || xo == 31);
    nanin = f_nan(ia) || f_nan(ib) || f_nan(ic);
    snan = (f_nan(ia) && !ia[51]) || (f_nan(ib) && !ib[51]) || (f_nan(ic) && !ic[51]);
    zmi = (f_zero(ia) && f_inf(ic)) || (f_inf(ia) && f_zero(ic));
    ps = ia[63] ^ ic[63];
    bs = ib[63] ^ sub;
    pinf = (f_inf(ia) || f_inf(ic)) && !zmi && !f_nan(ia) && !f_nan(ic);
    binf = f_inf(ib);
    isi = pinf && binf && ps != bs;
    e_fire = v && !e_ill && (nanin || zmi || pinf || binf || f_inf(ia) || f_inf(ic) || fv);
    if (f_nan(ia)) r = ia | (64'd1 << 51);
    else if (f_nan(ib)) r = ib | (64'd1 << 51);
    else if (f_nan(ic)) r = ic | (64'd1 << 51);
    else if (zmi || isi) r = DNAN;
    else if (pinf) r = {ps ^ neg, 11'h7FF, 52'd0};
    else if (binf) r = {bs ^ neg, 11'h7FF, 52'd0};
    else r = {fr[63] ^ neg, fr[62:0]};
    ovfr = fo && !(nanin || zmi || f_inf(ia) || f_inf(ic) || binf);
    if (e_fire) begin
      fxn = (zmi && !m_zmi) || (isi && !m_isi) || (snan && !m_snan) || (ovfr && !m_ovf);
      m_zmi |= zmi; m_isi |= isi; m_snan |= snan; m_ovf |= ovfr; m_fx |= fxn;
      m_res = r;
      if (rec) m_rec = {m_fx, ((m_zmi|m_isi|m_snan) & exc_en[1]) | (m_ovf & exc_en[0]),
                        m_zmi|m_isi|m_snan, m_ovf};
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "res_valid", res_valid, e_fire);
    if (e_fire) chk(tag, "res", res, m_res);
    chk(tag, "illegal", illegal, e_ill);
    chk(tag, "sticky", {inv_zmi, inv_inf_sub, inv_snan, ovf}, {m_zmi, m_isi, m_snan, m_ovf});
    chk(tag, "summary", exc_sum, m_fx);
    chk(tag, "inv_any", inv_any, m_zmi | m_isi | m_snan);
    chk(tag, "en_sum", en_sum, ((m_zmi|m_isi|m_snan) & exc_en[1]) | (m_ovf & exc_en[0]));
    chk(tag, "rec_valid", rec_valid, e_fire && rec);
    chk(tag, "rec_img", rec_img, m_rec);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // reset state
    chk("R1", "reset res_valid", res_valid, 0);
    chk("R7", "reset sticky", {inv_zmi, inv_inf_sub, inv_snan, ovf, exc_sum}, 0);
    chk("R9", "reset rec", {rec_valid, rec_img}, 0);
    rst_n = 1;
    idle("R1");
    // R1 finite path under each code
    step("R1", 1, 29, 0, ONE, ONE, ONE, 1, 64'h4008_0000_0000_0000, 0, 0);
    step("R1", 1, 28, 0, ONE, ONE, ONE, 1, 64'h8000_0000_0000_0000, 0, 0);
    step("R1", 1, 31, 0, ONE, ONE, ONE, 1, 64'h4008_0000_0000_0000, 0, 0);
    step("R1", 1, 30, 0, ONE, ONE, ONE, 1, 64'hC010_0000_0000_0001, 0, 0);
    step("R1", 1, 31, 0, ONE, ONE, ONE, 0, 64'h4008_0000_0000_0000, 0, 0);
    // R2 R3 NaN propagation and sign under negation
    step("R2", 1, 31, 0, NQNAN, ONE, ONE, 0, 0, 0, 0);
    step("R2", 1, 30, 0, ONE, NQNAN, QNAN1, 0, 0, 0, 0);
    step("R3", 1, 29, 0, ONE, SNAN1, QNAN1, 0, 0, 0, 0);
    step("R2", 1, 28, 0, QNAN1, SNAN1, NQNAN, 0, 0, 0, 0);
    step("R2", 1, 31, 0, ONE, ONE, {1'b1, SNAN1[62:0]}, 0, 0, 0, 1);
    step("R7", 1, 29, 0, ONE, ONE, ONE, 1, ONE, 0, 1);
    // R4 zero times infinity, both orders, plus NaN B
    step("R4", 1, 29, 0, ZERO, ONE, P_INF, 0, 0, 0, 0);
    step("R4", 1, 31, 0, N_INF, ONE, ZERO, 0, 0, 0, 1);
    step("R4", 1, 29, 0, ZERO, QNAN1, N_INF, 0, 0, 0, 1);
    // R5 R6 infinity sums with effective sign of B
    step("R5", 1, 29, 0, P_INF, N_INF, ONE, 0, 0, 0, 1);
    step("R5", 1, 28, 0, P_INF, P_INF, ONE, 0, 0, 0, 1);
    step("R6", 1, 28, 0, P_INF, N_INF, ONE, 0, 0, 0, 1);
    step("R6", 1, 31, 0, P_INF, P_INF, ONE, 0, 0, 0, 0);
    step("R6", 1, 30, 0, ONE, P_INF, ONE, 0, 0, 0, 0);
    step("R6", 1, 29, 0, ONE, ONE, N_INF, 0, 0, 0, 0);
    // R7 R8 R9 overflow path, enables and record image
    exc_en = 2'b01;
    step("R7", 1, 29, 1, ONE, ONE, ONE, 1, 64'h7FEF_FFFF_FFFF_FFFF, 1, 1);
    step("R7", 1, 29, 0, P_INF, ONE, ONE, 0, 0, 1, 1);
    exc_en = 2'b10;
    step("R9", 1, 30, 1, ZERO, ONE, P_INF, 0, 0, 0, 0);
    step("R8", 1, 30, 1, ZERO, ONE, P_INF, 0, 0, 0, 0);
    step("R9", 1, 29, 0, ONE, ONE, ONE, 1, ONE, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R10 illegal codes
    step("R10", 1, 5'd10, 1, SNAN1, ONE, ONE, 1, ONE, 1, 0);
    step("R10", 1, 5'd27, 0, ZERO, ONE, P_INF, 1, ONE, 0, 0);
    step("R8", 1, 29, 1, ONE, SNAN1, ONE, 0, 0, 0, 0);
    step("R10", 1, 5'd0, 0, ZERO, ONE, P_INF, 0, 0, 1, 0);
    idle("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule